// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one fixed-size page (512 bytes by default) between a flash data port and host memory. The page never goes straight across: it always passes through an on-board page buffer, so every transfer is made of two legs. The internal leg moves bytes between the flash port and the buffer. The memory leg moves bytes between the buffer and host memory over a simple byte-wide request/grant interface.

Software supplies a direction, a host physical address and a one-cycle start pulse. For a read, the internal leg runs first and the memory leg second. For a write, the order is reversed. A stage counter tracks progress. The block records a per-leg done status and an error status in a sticky register, cleared by writing ones, and raises an interrupt line while any status bit is set. An error input aborts the transfer at once. Whenever the host address is not actually needed, the address register is parked on a safe buffer address so that nothing can reach stray host memory.

Top module: `dma2_page_mover`

## Requirements
- R1: Each leg moves exactly PAGE_BYTES (512) bytes, one byte per granted request, byte i at buffer index i; during the memory leg mem_addr_o equals the leg address plus i.
- R2: With dir_rd_i=1 the internal leg runs first (fl_req_o with fl_we_o=0, flash into buffer) and the memory leg second (mem_req_o with mem_we_o=1), and host memory receives the flash bytes in order.
- R3: With dir_rd_i=0 the memory leg runs first (mem_req_o with mem_we_o=0, host into buffer) and the internal leg second (fl_req_o with fl_we_o=1), and the flash receives the host bytes in order.
- R4: The control bits are ctl_rd_o (read direction), ctl_int_o (internal leg selected) and ctl_mem_o (memory leg selected); exactly one leg select is set while a transfer is active and all three are 0 when idle.
- R5: stage_o is 1 from the cycle after an accepted start until the first leg's last byte, then 2 during the second leg; the leg-done event that would take it to 3 completes the transfer and stage_o reads 0 in the next cycle; busy_o is high whenever stage_o is not 0.
- R6: dma_addr_o holds the host address during the memory leg and SAFE_ADDR during the internal leg, after reset, after completion and after an abort.
- R7: sts_o bit 0 is internal-leg done, bit 1 memory-leg done, bit 2 error; each bit is set only when the same bit of irq_en_o is 1; irq_en_o is 3'b111 while a transfer is active and 0 otherwise; irq_o is the OR of sts_o.
- R8: A cycle with sts_clr_we_i=1 clears exactly the sts_o bits that are 1 in sts_clr_i and leaves the others; a set event in the same cycle wins over the clear.
- R9: err_i while active aborts: in the next cycle stage_o is 0, all control bits and enables are 0, dma_addr_o is SAFE_ADDR, sts_o bit 2 is set and no request is raised; the next transfer starts again at byte 0.
- R10: err_i, fl_gnt_i and mem_gnt_i while idle have no effect: no status bit is set and the byte position does not move.
- R11: start_i while busy is rejected: start_rej_o is 1 in the next cycle for one cycle and the running transfer continues with its original direction and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse |
| dir_rd_i | input | 1 | 1 = read (flash to host), 0 = write (host to flash) |
| host_addr_i | input | AW | Host physical address of the page |
| err_i | input | 1 | Error event, aborts an active transfer |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_i | input | 3 | Write-1-to-clear mask for sts_o |
| mem_req_o | output | 1 | Host memory byte request |
| mem_we_o | output | 1 | 1 = host write, 0 = host read |
| mem_addr_o | output | AW | Host byte address |
| mem_wdata_o | output | 8 | Byte written to host |
| mem_gnt_i | input | 1 | Host grant; byte moves in this cycle |
| mem_rdata_i | input | 8 | Byte read from host, valid with grant |
| fl_req_o | output | 1 | Flash data port byte request |
| fl_we_o | output | 1 | 1 = write to flash, 0 = read from flash |
| fl_wdata_o | output | 8 | Byte written to flash |
| fl_gnt_i | input | 1 | Flash grant; byte moves in this cycle |
| fl_rdata_i | input | 8 | Byte read from flash, valid with grant |
| ctl_rd_o | output | 1 | Control: read direction |
| ctl_int_o | output | 1 | Control: internal leg selected |
| ctl_mem_o | output | 1 | Control: memory leg selected |
| stage_o | output | 2 | Stage counter |
| dma_addr_o | output | AW | Address register |
| irq_en_o | output | 3 | Per-cause interrupt enables |
| sts_o | output | 3 | Sticky status: error, memory done, internal done |
| irq_o | output | 1 | Interrupt, OR of status |
| busy_o | output | 1 | Transfer active |
| start_rej_o | output | 1 | Start rejected because busy |

## Verification
The bench goes after the leg order in both directions, since a design that ignored the direction would push buffer garbage to the host or to the flash and the data comparison would fail. It checks the address register in every granted cycle, catching a design that exposes the host address during the internal leg or forgets to park it after completion or abort. It aborts a read in its first leg and then runs a fresh transfer, which exposes a byte counter that is not rewound (the next page would come out shifted) and status or enables left behind. It also pulses start mid-transfer and grants and errors while idle; a design that accepted those would switch direction, lose bytes or set status it should not.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_FIRST  = 2'd1,
    STG_SECOND = 2'd2,
    STG_DONE   = 2'd3
  } stage_e;

  localparam int ST_INT = 0;
  localparam int ST_MEM = 1;
  localparam int ST_ERR = 2;
  localparam int ST_W   = 3;

endpackage

// File: rtl/dma2_byte_ctr.sv
module dma2_byte_ctr #(
  parameter int PAGE_BYTES = 512,
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);

  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;

  assign last_o = (idx_q == IW'(PAGE_BYTES - 1));
  assign idx_en = clr_i | step_i;

  always_comb begin
    if (clr_i)       idx_d = '0;
    else if (last_o) idx_d = '0;
    else             idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !last_o) |=> (idx_q == $past(idx_q) + 1'b1));

  // R1
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_o) |=> (idx_q == '0));

endmodule

// File: rtl/dma2_page_buf.sv
module dma2_page_buf #(
  parameter int PAGE_BYTES = 512,
  parameter int DW = 8,
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] SAFE_ADDR = AW'('h1000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_rd_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic            err_i,
  input  logic            leg_done_i,
  input  logic            sts_clr_we_i,
  input  logic [ST_W-1:0] sts_clr_i,
  output logic            ctl_rd_o,
  output logic            ctl_int_o,
  output logic            ctl_mem_o,
  output logic [1:0]      stage_o,
  output logic [AW-1:0]   addr_o,
  output logic [ST_W-1:0] en_o,
  output logic [ST_W-1:0] sts_o,
  output logic            start_rej_o
);

  stage_e          stage_q, stage_d, stage_inc;
  logic            rd_q, rd_d, int_q, int_d, mem_q, mem_d;
  logic [AW-1:0]   addr_q, addr_d, host_q, host_d;
  logic [ST_W-1:0] en_q, en_d, sts_q, sts_d;
  logic            rej_q, rej_d;
  logic            active, cfg_upd;

  assign active    = (stage_q != STG_IDLE);
  assign cfg_upd   = active ? (err_i | leg_done_i) : start_i;
  assign stage_inc = stage_e'(stage_q + 2'd1);

  always_comb begin
    stage_d = stage_q;
    rd_d    = rd_q;
    int_d   = int_q;
    mem_d   = mem_q;
    addr_d  = addr_q;
    host_d  = host_q;
    en_d    = en_q;
    rej_d   = start_i & active;
    sts_d   = sts_q & ~(sts_clr_we_i ? sts_clr_i : '0);

    if (active && err_i) begin
      sts_d[ST_ERR] = sts_d[ST_ERR] | en_q[ST_ERR];
      stage_d = STG_IDLE;
      rd_d    = 1'b0;
      int_d   = 1'b0;
      mem_d   = 1'b0;
      en_d    = '0;
      addr_d  = SAFE_ADDR;
    end else if (!active && start_i) begin
      stage_d = STG_FIRST;
      rd_d    = dir_rd_i;
      int_d   = dir_rd_i;
      mem_d   = ~dir_rd_i;
      host_d  = host_addr_i;
      addr_d  = dir_rd_i ? SAFE_ADDR : host_addr_i;
      en_d    = '1;
    end else if (active && leg_done_i) begin
      sts_d[ST_INT] = sts_d[ST_INT] | (int_q & en_q[ST_INT]);
      sts_d[ST_MEM] = sts_d[ST_MEM] | (mem_q & en_q[ST_MEM]);
      if (stage_inc == STG_DONE) begin
        stage_d = STG_IDLE;
        rd_d    = 1'b0;
        int_d   = 1'b0;
        mem_d   = 1'b0;
        en_d    = '0;
        addr_d  = SAFE_ADDR;
      end else begin
        stage_d = stage_inc;
        int_d   = ~int_q;
        mem_d   = ~mem_q;
        addr_d  = int_q ? host_q : SAFE_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      rd_q    <= 1'b0;
      int_q   <= 1'b0;
      mem_q   <= 1'b0;
      addr_q  <= SAFE_ADDR;
      host_q  <= SAFE_ADDR;
      en_q    <= '0;
      sts_q   <= '0;
      rej_q   <= 1'b0;
    end else begin
      if (cfg_upd) begin
        stage_q <= stage_d;
        rd_q    <= rd_d;
        int_q   <= int_d;
        mem_q   <= mem_d;
        addr_q  <= addr_d;
        host_q  <= host_d;
        en_q    <= en_d;
      end
      sts_q <= sts_d;
      rej_q <= rej_d;
    end
  end

  assign ctl_rd_o    = rd_q;
  assign ctl_int_o   = int_q;
  assign ctl_mem_o   = mem_q;
  assign stage_o     = stage_q;
  assign addr_o      = addr_q;
  assign en_o        = en_q;
  assign sts_o       = sts_q;
  assign start_rej_o = rej_q;

  // R4
  leg_sel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones({int_q, mem_q}) == 1));

  // R4
  idle_ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> ({rd_q, int_q, mem_q, en_q} == '0));

  // R2
  rd_first_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start_i && dir_rd_i) |=> (int_q && stage_q == STG_FIRST));

  // R3
  wr_first_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start_i && !dir_rd_i) |=> (mem_q && stage_q == STG_FIRST));

  // R5
  second_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_FIRST && leg_done_i && !err_i) |=>
      (stage_q == STG_SECOND && int_q == !$past(int_q)));

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && err_i) |=> (stage_q == STG_IDLE && addr_q == SAFE_ADDR && en_q == '0));

  // R6
  int_leg_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_q |-> (addr_q == SAFE_ADDR));

  // R11
  busy_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start_i && !err_i && !leg_done_i) |=> (rej_q && $stable(host_q) && $stable(rd_q)));

endmodule

// File: rtl/dma2_page_mover.sv
module dma2_page_mover
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int PAGE_BYTES = 512,
  parameter logic [AW-1:0] SAFE_ADDR = AW'('h1000),
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_rd_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic            err_i,
  input  logic            sts_clr_we_i,
  input  logic [ST_W-1:0] sts_clr_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            fl_req_o,
  output logic            fl_we_o,
  output logic [7:0]      fl_wdata_o,
  input  logic            fl_gnt_i,
  input  logic [7:0]      fl_rdata_i,
  output logic            ctl_rd_o,
  output logic            ctl_int_o,
  output logic            ctl_mem_o,
  output logic [1:0]      stage_o,
  output logic [AW-1:0]   dma_addr_o,
  output logic [ST_W-1:0] irq_en_o,
  output logic [ST_W-1:0] sts_o,
  output logic            irq_o,
  output logic            busy_o
  ,output logic           start_rej_o
);

  logic          rst_meta_q, rst_sync_q;
  logic          xfer_int, xfer_mem, step, last, leg_done;
  logic          buf_we;
  logic [IW-1:0] idx;
  logic [7:0]    buf_wdata, buf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign fl_req_o  = ctl_int_o;
  assign fl_we_o   = ctl_int_o & ~ctl_rd_o;
  assign mem_req_o = ctl_mem_o;
  assign mem_we_o  = ctl_mem_o & ctl_rd_o;

  assign xfer_int  = fl_req_o & fl_gnt_i;
  assign xfer_mem  = mem_req_o & mem_gnt_i;
  assign step      = xfer_int | xfer_mem;
  assign leg_done  = step & last;

  assign buf_we    = (xfer_int & ctl_rd_o) | (xfer_mem & ~ctl_rd_o);
  assign buf_wdata = ctl_rd_o ? fl_rdata_i : mem_rdata_i;

  assign fl_wdata_o  = buf_rdata;
  assign mem_wdata_o = buf_rdata;
  assign mem_addr_o  = dma_addr_o + AW'(idx);
  assign busy_o      = (stage_o != 2'd0);
  assign irq_o       = |sts_o;

  dma2_byte_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr_i  (~busy_o),
    .step_i (step),
    .idx_o  (idx),
    .last_o (last)
  );

  dma2_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DW(8)) u_buf (
    .clk     (clk),
    .we_i    (buf_we),
    .addr_i  (idx),
    .wdata_i (buf_wdata),
    .rdata_o (buf_rdata)
  );

  dma2_seq #(.AW(AW), .SAFE_ADDR(SAFE_ADDR)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .start_i      (start_i),
    .dir_rd_i     (dir_rd_i),
    .host_addr_i  (host_addr_i),
    .err_i        (err_i),
    .leg_done_i   (leg_done),
    .sts_clr_we_i (sts_clr_we_i),
    .sts_clr_i    (sts_clr_i),
    .ctl_rd_o     (ctl_rd_o),
    .ctl_int_o    (ctl_int_o),
    .ctl_mem_o    (ctl_mem_o),
    .stage_o      (stage_o),
    .addr_o       (dma_addr_o),
    .en_o         (irq_en_o),
    .sts_o        (sts_o),
    .start_rej_o  (start_rej_o)
  );

  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy_o |-> (!fl_req_o && !mem_req_o && !buf_we));

  // R7
  sts_gated_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!busy_o && !start_i) |=> ((sts_o & ~$past(sts_o)) == '0));

endmodule

// File: tb/dma2_page_mover_bench.sv
`timescale 1ns/1ps
module dma2_page_mover_bench;

  localparam int AW = 32;
  localparam int PB = 512;
  localparam logic [31:0] SAFE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, dir_rd_i, err_i, sts_clr_we_i;
  logic [31:0] host_addr_i;
  logic [2:0]  sts_clr_i;
  logic        mem_req_o, mem_we_o, mem_gnt_i, fl_req_o, fl_we_o, fl_gnt_i;
  logic [31:0] mem_addr_o, dma_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, fl_wdata_o, fl_rdata_i;
  logic        ctl_rd_o, ctl_int_o, ctl_mem_o, irq_o, busy_o, start_rej_o;
  logic [1:0]  stage_o;
  logic [2:0]  irq_en_o, sts_o;

  always #2 clk = ~clk;

  dma2_page_mover #(.AW(AW), .PAGE_BYTES(PB), .SAFE_ADDR(SAFE)) u_dma2_page_mover (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
    .host_addr_i(host_addr_i), .err_i(err_i), .sts_clr_we_i(sts_clr_we_i),
    .sts_clr_i(sts_clr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
    .mem_rdata_i(mem_rdata_i), .fl_req_o(fl_req_o), .fl_we_o(fl_we_o),
    .fl_wdata_o(fl_wdata_o), .fl_gnt_i(fl_gnt_i), .fl_rdata_i(fl_rdata_i),
    .ctl_rd_o(ctl_rd_o), .ctl_int_o(ctl_int_o), .ctl_mem_o(ctl_mem_o),
    .stage_o(stage_o), .dma_addr_o(dma_addr_o), .irq_en_o(irq_en_o),
    .sts_o(sts_o), .irq_o(irq_o), .busy_o(busy_o), .start_rej_o(start_rej_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model of flash and host
  int          fl_idx, mem_idx, addr_err, stage_err, dir_err, first_leg;
  int          gnt_mode;
  logic [31:0] xbase;
  int          fseed, hseed;
  logic [7:0]  flash_got [PB];
  logic [7:0]  host_got  [PB];

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + (i >> 3)) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (gnt_mode == 1) begin
      fl_gnt_i  = 1'b1;
      mem_gnt_i = 1'b1;
    end else if (gnt_mode == 2) begin
      fl_gnt_i  = 1'b0;
      mem_gnt_i = 1'b0;
    end else begin
      fl_gnt_i  = ($urandom % 4) != 0;
      mem_gnt_i = ($urandom % 4) != 0;
    end
    fl_rdata_i  = pat(fseed, fl_idx);
    mem_rdata_i = pat(hseed, mem_idx);
    if (fl_req_o && fl_gnt_i) begin
      if (first_leg == 0) first_leg = 1;
      if (dma_addr_o != SAFE) addr_err++;
      if (stage_o != ((first_leg == 1) ? 2'd1 : 2'd2)) stage_err++;
      if (fl_we_o == ctl_rd_o) dir_err++;
      if (fl_idx < PB) flash_got[fl_idx] = fl_wdata_o;
      fl_idx++;
    end
    if (mem_req_o && mem_gnt_i) begin
      if (first_leg == 0) first_leg = 2;
      if (mem_addr_o != xbase + 32'(mem_idx)) addr_err++;
      if (stage_o != ((first_leg == 2) ? 2'd1 : 2'd2)) stage_err++;
      if (mem_we_o != ctl_rd_o) dir_err++;
      if (mem_idx < PB) host_got[mem_idx] = mem_wdata_o;
      mem_idx++;
    end
  end

  task automatic clear_model(input logic [31:0] base);
    fl_idx = 0; mem_idx = 0; addr_err = 0; stage_err = 0; dir_err = 0; first_leg = 0;
    xbase = base;
    fseed = int'($urandom % 1000);
    hseed = int'($urandom % 1000) + 1000;
  endtask

  task automatic begin_xfer(input bit dir, input logic [31:0] base);
    clear_model(base);
    @(negedge clk);
    start_i = 1'b1; dir_rd_i = dir; host_addr_i = base;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle;
    for (int n = 0; n < 6000 && busy_o; n++) @(negedge clk);
    chk(!busy_o, "R5 transfer finishes", busy_o, 0);
  endtask

  task automatic clear_sts(input logic [2:0] m);
    sts_clr_we_i = 1'b1; sts_clr_i = m;
    @(negedge clk);
    sts_clr_we_i = 1'b0; sts_clr_i = '0;
  endtask

  task automatic finish_xfer(input bit dir);
    int bad;
    wait_idle();
    bad = 0;
    for (int i = 0; i < PB; i++) begin
      if (dir && host_got[i] != pat(fseed, i)) bad++;
      if (!dir && flash_got[i] != pat(hseed, i)) bad++;
    end
    chk(fl_idx == PB, "R1 internal leg byte count", fl_idx, PB);
    chk(mem_idx == PB, "R1 memory leg byte count", mem_idx, PB);
    chk(bad == 0, dir ? "R2 read data to host" : "R3 write data to flash", bad, 0);
    chk(first_leg == (dir ? 1 : 2), dir ? "R2 internal leg first" : "R3 memory leg first", first_leg, dir ? 1 : 2);
    chk(dir_err == 0, "R2 R3 leg directions", dir_err, 0);
    chk(addr_err == 0, "R6 R1 address per leg", addr_err, 0);
    chk(stage_err == 0, "R5 stage per leg", stage_err, 0);
    chk(sts_o == 3'b011, "R7 done status", sts_o, 3'b011);
    chk(irq_o == 1'b1, "R7 irq on status", irq_o, 1);
    chk(dma_addr_o == SAFE, "R6 parked after done", dma_addr_o, SAFE);
    chk({irq_en_o, ctl_rd_o, ctl_int_o, ctl_mem_o, stage_o} == '0, "R4 R7 idle control", {irq_en_o, ctl_rd_o, ctl_int_o, ctl_mem_o, stage_o}, 0);
    clear_sts(3'b111);
    chk(sts_o == 3'b000 && !irq_o, "R8 full clear", sts_o, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; dir_rd_i = 1'b0; host_addr_i = '0;
    err_i = 1'b0; sts_clr_we_i = 1'b0; sts_clr_i = '0; gnt_mode = 2;
    fl_gnt_i = 1'b0; mem_gnt_i = 1'b0; fl_rdata_i = '0; mem_rdata_i = '0;
    clear_model(32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk(stage_o == 0 && !busy_o, "R5 reset stage", stage_o, 0);
    chk(sts_o == 0 && !irq_o, "R7 reset status", sts_o, 0);
    chk(dma_addr_o == SAFE, "R6 reset address", dma_addr_o, SAFE);
    chk(!fl_req_o && !mem_req_o, "R4 reset no requests", {fl_req_o, mem_req_o}, 0);

    // idle error and idle grants are ignored
    gnt_mode = 1;
    @(negedge clk); err_i = 1'b1;
    @(negedge clk); err_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(sts_o == 3'b000, "R10 idle error ignored", sts_o, 0);
    chk(fl_idx == 0 && mem_idx == 0, "R10 idle grants no transfer", fl_idx + mem_idx, 0);

    // directed read then write with continuous grants
    begin_xfer(1'b1, 32'h0004_0000);
    chk(stage_o == 2'd1 && ctl_int_o && ctl_rd_o, "R5 R2 stage one on read", {stage_o, ctl_int_o, ctl_rd_o}, 6'b0111);
    chk(irq_en_o == 3'b111, "R7 enables while active", irq_en_o, 3'b111);
    finish_xfer(1'b1);
    begin_xfer(1'b0, 32'h0008_0200);
    chk(stage_o == 2'd1 && ctl_mem_o && !ctl_rd_o, "R5 R3 stage one on write", {stage_o, ctl_mem_o, ctl_rd_o}, 6'b0110);
    finish_xfer(1'b0);

    // random grants, random directions and addresses
    gnt_mode = 0;
    for (int k = 0; k < 6; k++) begin
      bit d;
      logic [31:0] b;
      d = 1'($urandom % 2);
      b = $urandom & 32'hFFFF_FE00;
      begin_xfer(d, b);
      finish_xfer(d);
    end

    // start while busy is rejected
    begin_xfer(1'b1, 32'h0010_0000);
    repeat (100) @(negedge clk);
    start_i = 1'b1; dir_rd_i = 1'b0; host_addr_i = 32'hDEAD_0000;
    @(negedge clk);
    start_i = 1'b0;
    chk(start_rej_o == 1'b1, "R11 busy start flagged", start_rej_o, 1);
    chk(ctl_rd_o == 1'b1, "R11 direction kept", ctl_rd_o, 1);
    @(negedge clk);
    chk(start_rej_o == 1'b0, "R11 reject is one cycle", start_rej_o, 0);
    finish_xfer(1'b1);

    // partial write-1-to-clear
    begin_xfer(1'b0, 32'h0020_0000);
    wait_idle();
    clear_sts(3'b001);
    chk(sts_o == 3'b010, "R8 partial clear", sts_o, 3'b010);
    clear_sts(3'b010);
    chk(sts_o == 3'b000, "R8 second clear", sts_o, 0);

    // abort in the first leg of a read
    gnt_mode = 1;
    begin_xfer(1'b1, 32'h0030_0000);
    repeat (150) @(negedge clk);
    err_i = 1'b1;
    @(negedge clk);
    err_i = 1'b0;
    chk(stage_o == 0 && !busy_o, "R9 abort stage zero", stage_o, 0);
    chk(sts_o == 3'b100, "R9 abort error status", sts_o, 3'b100);
    chk(dma_addr_o == SAFE, "R9 R6 abort parks address", dma_addr_o, SAFE);
    chk({irq_en_o, ctl_rd_o, ctl_int_o, ctl_mem_o} == '0, "R9 abort clears control", {irq_en_o, ctl_rd_o, ctl_int_o, ctl_mem_o}, 0);
    repeat (3) @(negedge clk);
    chk(!fl_req_o && !mem_req_o && mem_idx == 0, "R9 no request after abort", {fl_req_o, mem_req_o}, 0);
    clear_sts(3'b100);

    // fresh transfer after abort restarts at byte 0
    gnt_mode = 0;
    begin_xfer(1'b1, 32'h0040_0000);
    finish_xfer(1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule